// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two buses, called the A side and the B side. The 16-bit path is cut into two 8-bit sections, and each section has its own control set. In each section, each direction has three controls. A drive enable turns the direction on. A source select picks between the live value on the opposite bus and a value held in that direction's capture register. A capture strobe loads the register when it rises.

The bidirectional pins are modelled as three signals per side: an input vector, an output vector and one output-enable flag per section. A pad ring or a board-level tri-state wrapper can combine these later. A capture strobe rises once and then the register stays put. This lets one section freeze a snapshot of bus traffic while the other direction keeps driving its bus with live or stored data.

The block runs on one system clock. A capture strobe is sampled on that clock. A strobe that is low on one edge and high on the next counts as a rising edge.

Top module: `xcvr_bus`

## Requirements
- R1: Section s occupies bits [8s+7:8s] of every bus vector and is governed only by bit s of each control vector. Section 0 is bits 7:0 and section 1 is bits 15:8.
- R2: Drive enables are active high. When `en_ab[s]` is low, `b_oe[s]` is 0 and section s of `b_out` is all zeros. When it is high, `b_oe[s]` is 1. The same rule ties `en_ba`, `a_oe` and `a_out`.
- R3: With the drive enabled and the select low (0 = live), the output section equals the opposite bus input section in the same cycle, with no register in the path.
- R4: If `cap_ab[s]` is low at one clock edge and high at the next, that second edge stores section s of `a_in` in the A-to-B register. `cap_ba` does the same for `b_in`. With the select high (1 = stored), the new value appears on the output after that edge.
- R5: Without a new rising edge of its strobe, a capture register keeps its value across any input change. A strobe held high captures only once.
- R6: Capture happens whatever the drive enable and select are. A value captured while the outputs are disabled appears once they are enabled in stored mode.
- R7: Both directions of a section, and both sections, may capture on the same clock edge.
- R8: When a select changes while both of its sources are steady, the output takes only the old source value or the new one. Bits on which the two sources agree never change.
- R9: A synchronous active-high `rst` clears every capture register to zero. Stored mode therefore outputs zeros before the first capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; capture strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the capture registers |
| a_in | input | 16 | Value present on the A bus |
| a_out | output | 16 | Value to drive onto the A bus (B-to-A direction) |
| a_oe | output | 2 | Per-section drive flag for the A bus |
| b_in | input | 16 | Value present on the B bus |
| b_out | output | 16 | Value to drive onto the B bus (A-to-B direction) |
| b_oe | output | 2 | Per-section drive flag for the B bus |
| en_ab | input | 2 | Per-section enable for driving B from A |
| en_ba | input | 2 | Per-section enable for driving A from B |
| sel_ab | input | 2 | Per-section A-to-B source: 0 live, 1 stored |
| sel_ba | input | 2 | Per-section B-to-A source: 0 live, 1 stored |
| cap_ab | input | 2 | Per-section strobe that captures `a_in` on its rise |
| cap_ba | input | 2 | Per-section strobe that captures `b_in` on its rise |

## Verification
Live data, drive flags and select changes reach the outputs with no clock edge in between. A captured value shows up only after the clock edge that sees its strobe rise, one register later. The bench changes inputs on the falling edge. It samples just before the next falling edge, so every result covers exactly one rising edge, and that edge is the one that carries any capture. The select-switch check samples at several points inside one half cycle, with no edge in that window.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int SECT_W_DEF = 8;
    localparam int N_SECT_DEF = 2;

    // control set of one direction in one section
    typedef struct packed {
        logic en;   // drive enable, active high
        logic sel;  // 0 = live source, 1 = captured source
        logic cap;  // capture strobe, acts on its rise
    } dir_ctl_t;

    function automatic logic rose_now(input logic now_v, input logic before_v);
        return now_v & ~before_v;
    endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture
    import xcvr_pkg::*;
#(
    parameter int W = SECT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic cap_d;
    logic load;

    assign load = rose_now(cap, cap_d);

    always_ff @(posedge clk) begin
        cap_d <= cap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    p_load_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cap) |=> (q == $past(d)));

    p_hold_without_rise_r5: assert property (@(posedge clk) disable iff (rst)
        !$rose(cap) |=> $stable(q));

    p_clear_r9: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W = SECT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] live,
    output logic [W-1:0] out,
    output logic         oe
);

    logic [W-1:0] held;
    logic [W-1:0] pick;
    logic [W-1:0] sel_v;

    xcvr_capture #(.W(W)) u_cap (
        .clk (clk),
        .rst (rst),
        .cap (ctl.cap),
        .d   (live),
        .q   (held)
    );

    // sum-of-products mux with consensus term: bits on which both
    // sources agree are held by (live & held) while sel changes
    assign sel_v = {W{ctl.sel}};

    always_comb begin
        pick = (live & ~sel_v) | (held & sel_v) | (live & held);
        out  = ctl.en ? pick : '0;
        oe   = ctl.en;
    end

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |-> (out == '0 && !oe));

    p_live_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctl.sel) |-> (out == live));

    p_clean_switch_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && $stable(live) && $stable(held)) |-> (out == live || out == held));

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int W = SECT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl_ab,
    input  dir_ctl_t     ctl_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_oe,
    output logic         b_oe
);

    xcvr_path #(.W(W)) u_ab (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl_ab),
        .live (a_in),
        .out  (b_out),
        .oe   (b_oe)
    );

    xcvr_path #(.W(W)) u_ba (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl_ba),
        .live (b_in),
        .out  (a_out),
        .oe   (a_oe)
    );

endmodule

// File: rtl/xcvr_bus.sv
module xcvr_bus
    import xcvr_pkg::*;
#(
    parameter int SECT_W = SECT_W_DEF,
    parameter int N_SECT = N_SECT_DEF,
    localparam int BUS_W = SECT_W * N_SECT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  a_in,
    output logic [BUS_W-1:0]  a_out,
    output logic [N_SECT-1:0] a_oe,
    input  logic [BUS_W-1:0]  b_in,
    output logic [BUS_W-1:0]  b_out,
    output logic [N_SECT-1:0] b_oe,
    input  logic [N_SECT-1:0] en_ab,
    input  logic [N_SECT-1:0] en_ba,
    input  logic [N_SECT-1:0] sel_ab,
    input  logic [N_SECT-1:0] sel_ba,
    input  logic [N_SECT-1:0] cap_ab,
    input  logic [N_SECT-1:0] cap_ba
);

    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
        dir_ctl_t ctl_ab;
        dir_ctl_t ctl_ba;

        assign ctl_ab = '{en: en_ab[s], sel: sel_ab[s], cap: cap_ab[s]};
        assign ctl_ba = '{en: en_ba[s], sel: sel_ba[s], cap: cap_ba[s]};

        xcvr_section #(.W(SECT_W)) u_sect (
            .clk    (clk),
            .rst    (rst),
            .ctl_ab (ctl_ab),
            .ctl_ba (ctl_ba),
            .a_in   (a_in[s*SECT_W +: SECT_W]),
            .b_in   (b_in[s*SECT_W +: SECT_W]),
            .a_out  (a_out[s*SECT_W +: SECT_W]),
            .b_out  (b_out[s*SECT_W +: SECT_W]),
            .a_oe   (a_oe[s]),
            .b_oe   (b_oe[s])
        );
    end

endmodule

// File: tb/xcvr_bus_bench.sv
module xcvr_bus_bench;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic [1:0]  eab;
        logic [1:0]  eba;
        logic [1:0]  sab;
        logic [1:0]  sba;
        logic [1:0]  cab;
        logic [1:0]  cba;
        logic [15:0] xa;
        logic [15:0] xb;
        logic [1:0]  xaoe;
        logic [1:0]  xboe;
    } row_t;

    localparam int NROW = 9;
    localparam row_t TAB [NROW] = '{
        // R3: live both ways
        '{16'h1234, 16'hABCD, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'hABCD, 16'h1234, 2'b11, 2'b11},
        // R9: stored mode before any capture gives zeros
        '{16'h1234, 16'hABCD, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 16'h0000, 16'h0000, 2'b11, 2'b11},
        // R4: rising cap_ab stores a_in
        '{16'h5AA5, 16'hABCD, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 16'h0000, 16'h5AA5, 2'b11, 2'b11},
        // R5: strobe held high, a_in changes, register holds
        '{16'hFFFF, 16'hABCD, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 16'h0000, 16'h5AA5, 2'b11, 2'b11},
        // R3: A-to-B back to live
        '{16'h0F0F, 16'hABCD, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00, 16'h0000, 16'h0F0F, 2'b11, 2'b11},
        // R2 R6 R1: outputs off, capture sec0 A-to-B and sec1 B-to-A
        '{16'h1122, 16'h3344, 2'b00, 2'b00, 2'b11, 2'b11, 2'b01, 2'b10, 16'h0000, 16'h0000, 2'b00, 2'b00},
        // R6: enabled stored view shows the disabled-time captures
        '{16'h0000, 16'h0000, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 16'h3300, 16'h5A22, 2'b11, 2'b11},
        // R1 R2: sections configured differently
        '{16'h55C3, 16'h7E99, 2'b01, 2'b10, 2'b10, 2'b01, 2'b00, 2'b00, 16'h7E00, 16'h00C3, 2'b10, 2'b01},
        // R7: all four registers capture on one edge
        '{16'hA1B2, 16'hC3D4, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 16'hC3D4, 16'hA1B2, 2'b11, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] a_in, b_in, a_out, b_out;
    logic [1:0]  a_oe, b_oe, en_ab, en_ba, sel_ab, sel_ba, cap_ab, cap_ba;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    xcvr_bus u_xcvr_bus (
        .clk    (clk),
        .rst    (rst),
        .a_in   (a_in),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_in   (b_in),
        .b_out  (b_out),
        .b_oe   (b_oe),
        .en_ab  (en_ab),
        .en_ba  (en_ba),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .cap_ab (cap_ab),
        .cap_ba (cap_ba)
    );

    task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got a_out/b_out/a_oe/b_oe=%h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input row_t r);
        a_in = r.a;  b_in = r.b;
        en_ab = r.eab;  en_ba = r.eba;
        sel_ab = r.sab; sel_ba = r.sba;
        cap_ab = r.cab; cap_ba = r.cba;
    endtask

    initial begin
        #4000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        en_ab = 2'b11; en_ba = 2'b11; sel_ab = 2'b11; sel_ba = 2'b11;
        cap_ab = 2'b00; cap_ba = 2'b00;
        repeat (2) @(negedge clk);
        // R9: reset state in stored mode
        check("R9 reset", {a_out, b_out, a_oe, b_oe}, {16'h0, 16'h0, 2'b11, 2'b11});
        rst = 1'b0;

        for (int i = 0; i < NROW; i++) begin
            drive(TAB[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("table row %0d", i), {a_out, b_out, a_oe, b_oe},
                  {TAB[i].xa, TAB[i].xb, TAB[i].xaoe, TAB[i].xboe});
        end

        // R5: strobe low, inputs keep changing for several edges
        cap_ab = 2'b00; cap_ba = 2'b00;
        for (int k = 0; k < 3; k++) begin
            a_in = 16'h1111 * k; b_in = ~(16'h2222 * k);
            @(posedge clk);
            @(negedge clk);
            check("R5 hold", {a_out, b_out, a_oe, b_oe}, {16'hC3D4, 16'hA1B2, 2'b11, 2'b11});
        end

        // R8: stored A1B2 vs live A1F2, switch select mid half-cycle
        a_in = 16'hA1F2;
        #2;
        sel_ab = 2'b00;
        for (int k = 0; k < 4; k++) begin
            check("R8 switch old-or-new", {15'h0, (b_out == 16'hA1B2 || b_out == 16'hA1F2), 4'h0, 16'h0},
                  {15'h0, 1'b1, 4'h0, 16'h0});
            check("R8 agreeing bits steady", {4'h0, b_out & 16'hFFBF, 16'h0}, {4'h0, 16'hA1B2, 16'h0});
            #1;
        end
        check("R3 live after switch", {20'h0, b_out}, {20'h0, 16'hA1F2});

        // R9: mid-run reset clears both registers
        @(negedge clk);
        sel_ab = 2'b11; sel_ba = 2'b11;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid-run clear", {a_out, b_out, a_oe, b_oe}, {16'h0, 16'h0, 2'b11, 2'b11});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule